// File: doc/BRIEF.md
# Three-Phase Dead-Time PWM Timing Unit

This block drives six active-low gate signals for a three-phase bridge. Each phase has a high-side gate and a low-side gate. A shared up/down counter runs through a rising half and then a falling half. Each phase compares the counter against its own duty value, the half-period length and the dead time, and from that decides whether its high-side or low-side device is commanded on. Dead time is taken from both sides of the nominal switching instant by the same amount. Because of this, the pair of gates for a phase is never on at the same time, and the pulses stay centred when the values do not change.

The block reads its inputs only at fixed moments. The duty values, the half-period and the dead time are copied into working registers at the start of every period. In double-update mode they are also copied at the midpoint, so the falling half can use its own values and produce asymmetric pulses. A one-bit output reports which half of the period is in progress. All outputs come from registers.

Top module: `pwm3_deadtime_timer`

## Requirements
- R1: While reset is high, and in the cycle after reset is sampled, all six gate outputs are 1 (device off) and `second_half_o` is 0. A gate output of 0 means "device on".
- R2: The rising half lasts HP cycles and the falling half lasts HP cycles. HP is the half-period value in effect for that half. A half-period value of 0 is treated as 1.
- R3: Number the cycles in a half by counter value c. The rising half runs c = 0 to HP-1 and the falling half runs c = HP-1 down to 0. A phase's high-side gate is on exactly when c + duty >= HP + deadtime. Over one half this gives max(0, min(HP, duty - deadtime)) on-cycles.
- R4: A phase's low-side gate is on exactly when c + duty + deadtime < HP.
- R5: The high-side and low-side gates of one phase are never both 0 in the same cycle.
- R6: In single-update mode, input changes made during a period have no effect until the next period begins. The falling half repeats the values of the rising half.
- R7: In double-update mode, the inputs present when the rising half ends are copied in, including the half-period. They govern the falling half.
- R8: `second_half_o` is 0 during the rising half and 1 during the falling half. It is aligned with the gate outputs.
- R9: If duty <= deadtime, the high-side gate stays off for the whole half. If duty + deadtime >= HP, the low-side gate stays off for the whole half.
- R10: The three phases are independent. Each uses only its own duty input, together with the shared half-period and dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset. Also copies the inputs into the working registers |
| dbl_mode_i | input | 1 | 1 = reload the working values at the midpoint as well, 0 = reload only at the period start |
| half_period_i | input | W | Half-period length in cycles |
| dead_time_i | input | W | Dead time in cycles, applied to each edge |
| duty_a_i | input | W | Phase A high-side on-time per half, in cycles |
| duty_b_i | input | W | Phase B duty |
| duty_c_i | input | W | Phase C duty |
| gate_hi_n_o | output | 3 | High-side gates, active low. Bit 0 = A, bit 1 = B, bit 2 = C |
| gate_lo_n_o | output | 3 | Low-side gates, active low. Same bit order |
| second_half_o | output | 1 | 1 during the falling half of the period |

## Verification
The bench goes after the edges of the comparison window:
- duty at or below the dead time, where a design off by one would leave a one-cycle high-side sliver;
- duty plus dead time at or beyond the half-period, where a bad clamp would wrap and turn the low side on;
- duty above the half-period, where the high side must saturate at HP cycles instead of overflowing.

It also drives a half-period of 1 and of 0. A counter that wraps at HP rather than turning at HP-1 would stretch the halves.

Mid-period input changes are made in both modes. A single-update design that leaked them would skew the falling half. A double-update design that did not reload the half-period would give a falling half of the wrong length.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int unsigned PHASES = 3;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    // One phase's gate pair, both active low
    typedef struct packed {
        logic hi_n;
        logic lo_n;
    } gate_pair_t;

    localparam gate_pair_t GATES_OFF = '{hi_n: 1'b1, lo_n: 1'b1};

endpackage

// File: rtl/pwm3_counter.sv
module pwm3_counter
    import pwm3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dbl_mode,
    input  logic [W-1:0] hp_cur,      // clamped half-period in force
    input  logic [W-1:0] hp_next,     // clamped half-period at the inputs
    output logic [W-1:0] cnt,
    output cnt_dir_e     dir,
    output logic         load         // working copies reload at this edge
);

    logic at_top;
    logic at_bottom;
    logic load_mid;
    logic load_start;

    assign at_top     = (dir == CNT_UP)   && (cnt == hp_cur - W'(1));
    assign at_bottom  = (dir == CNT_DOWN) && (cnt == '0);
    assign load_mid   = at_top && dbl_mode;
    assign load_start = at_bottom;
    assign load       = load_mid || load_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dir <= CNT_UP;
        end else if (dir == CNT_UP) begin
            if (at_top) begin
                dir <= CNT_DOWN;
                cnt <= load_mid ? (hp_next - W'(1)) : cnt;
            end else begin
                cnt <= cnt + W'(1);
            end
        end else begin
            if (at_bottom) begin
                dir <= CNT_UP;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm3_shadow.sv
module pwm3_shadow
    import pwm3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [PHASES-1:0][W-1:0] duty_in,
    input  logic [W-1:0]             hp_in,
    input  logic [W-1:0]             dt_in,
    output logic [PHASES-1:0][W-1:0] duty_wk,
    output logic [W-1:0]             hp_wk,
    output logic [W-1:0]             dt_wk
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            duty_wk <= duty_in;
            hp_wk   <= hp_in;
            dt_wk   <= dt_in;
        end
    end

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
    import pwm3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] hp,
    input  logic [W-1:0] dt,
    input  logic [W-1:0] duty,
    output gate_pair_t   gate_o
);

    localparam int SW = W + 2;

    logic [SW-1:0] pos_sum;
    logic [SW-1:0] hi_limit;
    logic [SW-1:0] lo_sum;
    logic          hi_on;
    logic          lo_on;

    assign pos_sum  = SW'(cnt) + SW'(duty);
    assign hi_limit = SW'(hp) + SW'(dt);
    assign lo_sum   = pos_sum + SW'(dt);
    assign hi_on    = (pos_sum >= hi_limit);
    assign lo_on    = (lo_sum < SW'(hp));

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o <= GATES_OFF;
        end else begin
            gate_o.hi_n <= ~hi_on;
            gate_o.lo_n <= ~lo_on;
        end
    end

endmodule

// File: rtl/pwm3_deadtime_timer.sv
module pwm3_deadtime_timer
    import pwm3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dbl_mode_i,
    input  logic [W-1:0] half_period_i,
    input  logic [W-1:0] dead_time_i,
    input  logic [W-1:0] duty_a_i,
    input  logic [W-1:0] duty_b_i,
    input  logic [W-1:0] duty_c_i,
    output logic [2:0]   gate_hi_n_o,
    output logic [2:0]   gate_lo_n_o,
    output logic         second_half_o
);

    logic [PHASES-1:0][W-1:0] duty_in;
    logic [PHASES-1:0][W-1:0] wk_duty;
    logic [W-1:0]             wk_hp;
    logic [W-1:0]             wk_dt;
    logic [W-1:0]             hp_eff;
    logic [W-1:0]             hp_in_eff;
    logic [W-1:0]             cnt;
    cnt_dir_e                 dir;
    logic                     load;
    gate_pair_t               pair [PHASES];

    assign duty_in[0] = duty_a_i;
    assign duty_in[1] = duty_b_i;
    assign duty_in[2] = duty_c_i;

    assign hp_eff    = (wk_hp == '0)         ? W'(1) : wk_hp;
    assign hp_in_eff = (half_period_i == '0) ? W'(1) : half_period_i;

    pwm3_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .dbl_mode (dbl_mode_i),
        .hp_cur   (hp_eff),
        .hp_next  (hp_in_eff),
        .cnt      (cnt),
        .dir      (dir),
        .load     (load)
    );

    pwm3_shadow #(.W(W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .duty_in (duty_in),
        .hp_in   (half_period_i),
        .dt_in   (dead_time_i),
        .duty_wk (wk_duty),
        .hp_wk   (wk_hp),
        .dt_wk   (wk_dt)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        pwm3_phase #(.W(W)) u_phase (
            .clk    (clk),
            .rst    (rst),
            .cnt    (cnt),
            .hp     (hp_eff),
            .dt     (wk_dt),
            .duty   (wk_duty[p]),
            .gate_o (pair[p])
        );
        assign gate_hi_n_o[p] = pair[p].hi_n;
        assign gate_lo_n_o[p] = pair[p].lo_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            second_half_o <= 1'b0;
        end else begin
            second_half_o <= (dir == CNT_DOWN);
        end
    end

endmodule

// File: rtl/pwm3_checker.sv
module pwm3_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         dbl_mode,
    input logic [2:0]   gate_hi_n,
    input logic [2:0]   gate_lo_n,
    input logic         sec_half,
    input logic [W-1:0] cnt,
    input logic [W-1:0] hp_eff,
    input logic         dir_down,
    input logic [W-1:0] wk_hp,
    input logic [W-1:0] wk_duty_a,
    input logic [W-1:0] wk_dt,
    input logic [W-1:0] hp_in
);

    // R5: a phase's two devices are never commanded on together
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        (gate_hi_n | gate_lo_n) == 3'b111);

    // R1: reset leaves every gate off and the half flag clear
    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> (gate_hi_n == 3'b111 && gate_lo_n == 3'b111 && !sec_half));

    // R2: the counter stays inside the half-period in force
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt < hp_eff);

    // R6: no reload at the midpoint in single-update mode
    assert_single_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(dir_down) && dir_down && !$past(dbl_mode))
        |-> (wk_hp == $past(wk_hp) && wk_duty_a == $past(wk_duty_a)));

    // R7: the midpoint in double-update mode takes the half-period from the inputs
    assert_dbl_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(dir_down) && dir_down && $past(dbl_mode))
        |-> (wk_hp == $past(hp_in)));

    // R9: a duty no larger than the dead time keeps phase A's high side off
    assert_dead_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(wk_duty_a) <= $past(wk_dt)) |-> gate_hi_n[0]);

endmodule

bind pwm3_deadtime_timer pwm3_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbl_mode  (dbl_mode_i),
    .gate_hi_n (gate_hi_n_o),
    .gate_lo_n (gate_lo_n_o),
    .sec_half  (second_half_o),
    .cnt       (cnt),
    .hp_eff    (hp_eff),
    .dir_down  (dir == pwm3_pkg::CNT_DOWN),
    .wk_hp     (wk_hp),
    .wk_duty_a (wk_duty[0]),
    .wk_dt     (wk_dt),
    .hp_in     (half_period_i)
);

// File: tb/pwm3_deadtime_timer_tb.sv
module pwm3_deadtime_timer_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dbl_mode_i = 1'b0;
    logic [W-1:0] half_period_i = '0;
    logic [W-1:0] dead_time_i = '0;
    logic [W-1:0] duty_a_i = '0;
    logic [W-1:0] duty_b_i = '0;
    logic [W-1:0] duty_c_i = '0;
    logic [2:0]   gate_hi_n_o;
    logic [2:0]   gate_lo_n_o;
    logic         second_half_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // settings for the rising half (a) and the falling half (b)
    int a_hp, a_dt;
    int a_d [3];
    int b_hp, b_dt;
    int b_d [3];

    always #4 clk = ~clk;

    pwm3_deadtime_timer #(.W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .dbl_mode_i    (dbl_mode_i),
        .half_period_i (half_period_i),
        .dead_time_i   (dead_time_i),
        .duty_a_i      (duty_a_i),
        .duty_b_i      (duty_b_i),
        .duty_c_i      (duty_c_i),
        .gate_hi_n_o   (gate_hi_n_o),
        .gate_lo_n_o   (gate_lo_n_o),
        .second_half_o (second_half_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp_hp(input int hp);
        return (hp == 0) ? 1 : hp;
    endfunction

    task automatic drive(input int hp, input int dt, input int d0, input int d1, input int d2);
        half_period_i = W'(hp);
        dead_time_i   = W'(dt);
        duty_a_i      = W'(d0);
        duty_b_i      = W'(d1);
        duty_c_i      = W'(d2);
    endtask

    task automatic wait_start();
        bit prev;
        prev = second_half_o;
        forever begin
            @(negedge clk);
            if (prev && !second_half_o) break;
            prev = second_half_o;
        end
    endtask

    // compare one cycle against R3/R4/R5 for all phases
    task automatic check_cycle(input int c, input int hp, input int dt, input int d0,
                               input int d1, input int d2);
        int dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        for (int p = 0; p < 3; p++) begin
            bit hi_exp;
            bit lo_exp;
            hi_exp = (c + dv[p] >= hp + dt);
            lo_exp = (c + dv[p] + dt < hp);
            // R3 R9 R10: high-side window per phase
            check(gate_hi_n_o[p] == !hi_exp, "R3 high side", int'(gate_hi_n_o[p]), int'(!hi_exp));
            // R4 R9 R10: low-side window per phase
            check(gate_lo_n_o[p] == !lo_exp, "R4 low side", int'(gate_lo_n_o[p]), int'(!lo_exp));
            // R5: never both on
            check(gate_hi_n_o[p] || gate_lo_n_o[p], "R5 overlap", 0, 1);
        end
    endtask

    // Measure one period. 'a' values are applied ahead; 'b' values go on the inputs in the
    // first cycle of the rising half when change_mid is set.
    task automatic run_period(input bit dbl, input bit change_mid);
        int hpa, hpb;
        int bhp, bdt, bd0, bd1, bd2;
        int i, j;
        dbl_mode_i = dbl;
        drive(a_hp, a_dt, a_d[0], a_d[1], a_d[2]);
        wait_start();
        wait_start();
        hpa = clamp_hp(a_hp);
        if (dbl && change_mid) begin
            bhp = b_hp; bdt = b_dt; bd0 = b_d[0]; bd1 = b_d[1]; bd2 = b_d[2];
        end else begin
            bhp = a_hp; bdt = a_dt; bd0 = a_d[0]; bd1 = a_d[1]; bd2 = a_d[2];
        end
        hpb = clamp_hp(bhp);
        i = 0;
        while (!second_half_o) begin
            check_cycle(i, hpa, a_dt, a_d[0], a_d[1], a_d[2]);
            if (i == 0 && change_mid) drive(b_hp, b_dt, b_d[0], b_d[1], b_d[2]);
            i++;
            @(negedge clk);
        end
        // R2 R8: rising half length
        check(i == hpa, "R2 R8 rising half length", i, hpa);
        j = 0;
        while (second_half_o) begin
            // R6 R7: falling half uses the right copy
            check_cycle(hpb - 1 - j, hpb, bdt, bd0, bd1, bd2);
            j++;
            @(negedge clk);
        end
        // R2 R7 R8: falling half length
        check(j == hpb, "R2 R7 R8 falling half length", j, hpb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        drive(4, 1, 2, 2, 2);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(gate_hi_n_o == 3'b111, "R1 reset high gates", int'(gate_hi_n_o), 7);
        check(gate_lo_n_o == 3'b111, "R1 reset low gates", int'(gate_lo_n_o), 7);
        check(second_half_o == 1'b0, "R1 reset half flag", int'(second_half_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3 R4 R9 R10: single-update sweep over small half-periods
        for (int hp = 1; hp <= 6; hp++) begin
            for (int dt = 0; dt <= 3; dt++) begin
                for (int d = 0; d <= hp + 2; d++) begin
                    a_hp = hp; a_dt = dt;
                    a_d[0] = d;
                    a_d[1] = (hp - d > 0) ? hp - d : 0;
                    a_d[2] = d / 2 + dt;
                    run_period(1'b0, 1'b0);
                end
            end
        end

        // R2: half-period of zero counts as one
        a_hp = 0; a_dt = 0; a_d[0] = 1; a_d[1] = 0; a_d[2] = 3;
        run_period(1'b0, 1'b0);

        // R6: mid-period changes ignored in single-update mode
        for (int k = 0; k < 4; k++) begin
            a_hp = 5; a_dt = 1; a_d[0] = 2 + k; a_d[1] = 4; a_d[2] = 1;
            b_hp = 3; b_dt = 0; b_d[0] = 0; b_d[1] = 1; b_d[2] = 3 - k;
            run_period(1'b0, 1'b1);
        end

        // R7: double update gives an asymmetric falling half, half-period included
        for (int hb = 1; hb <= 7; hb++) begin
            for (int dt = 0; dt <= 2; dt++) begin
                a_hp = 4; a_dt = 1; a_d[0] = 3; a_d[1] = 1; a_d[2] = 4;
                b_hp = hb; b_dt = dt; b_d[0] = hb - 1; b_d[1] = 0; b_d[2] = hb + 1;
                run_period(1'b1, 1'b1);
            end
        end

        // R7: double update with the same values stays symmetric
        a_hp = 6; a_dt = 2; a_d[0] = 4; a_d[1] = 2; a_d[2] = 7;
        run_period(1'b1, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule